// File: doc/BRIEF.md
# Bridge Power-State Transaction Gate

This block lives on the primary side of a bus-to-bus bridge. It holds the bridge's device power state and decides, for every incoming request, whether the bridge claims it, passes it on to the secondary bus, or leaves it unclaimed so that the initiator sees a master abort. Power management software changes the state by writing a Type 0 configuration word. The same word also carries a standard configuration field and a vendor field, and a Type 0 read returns all three.

Below full power, memory and I/O traffic is refused. Configuration traffic still gets an answer: Type 1 cycles are claimed locally and never forwarded, their writes are dropped, and their reads return all ones. In the deeper sleep levels the block switches the secondary clock enables off. When software wakes the bridge from the hot-off level straight to fully on, the block emits a one-cycle internal reset. That reset clears the standard field and leaves the vendor field and the power state alone.

A separate cold-off input models loss of power. While it is high, every request goes unclaimed, the clocks stay off and all registers are held at their defaults.

Top module: `pgate_top`

## Requirements
- R1: After reset the power state is fully on (code 00) and all fields are zero. A Type 0 read returns the status word {standard[31:16], vendor[15:2], state[1:0]}. Every response (rspValid, claim, forward, abort, read data) appears on the clock edge that follows the request, and the response outputs are low when no request was made.
- R2: Request types are coded 00 memory, 01 I/O, 10 Type 0 configuration and 11 Type 1 configuration. In the fully-on state (00), memory, I/O and Type 1 requests are claimed and forwarded, with read data zero.
- R3: In the states coded 01, 10 and 11, memory and I/O requests are not claimed and not forwarded, and abort is raised.
- R4: In all four coded states, Type 0 requests are claimed and not forwarded. A Type 0 write loads state from data bits [1:0], vendor from [15:2] and standard from [31:16].
- R5: In states 01, 10 and 11, Type 1 requests are claimed and not forwarded. A Type 1 read returns 32'hFFFF_FFFF, and a Type 1 write changes no register.
- R6: All secondary clock enables are high in states 00 and 01 and low in states 10 and 11. They take their new value in the cycle after the edge that writes the state.
- R7: A Type 0 write that moves the state from 11 to 00 raises softRst for exactly one cycle after that edge. The same edge clears the standard field, even against the written data, while the vendor field takes the written value.
- R8: No other state change (for example 11 to 01, or 10 to 00) raises softRst, and the standard field then takes the written value.
- R9: While coldOff is high, every request is unclaimed and aborted with zero read data, the clock enables are low, writes are ignored, and all registers are held at their defaults. After coldOff falls, the status word reads zero.
- R10: errOut follows errIn one cycle later in every coded power state. It is held low while coldOff is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| coldOff | input | 1 | Cold power-off condition |
| reqValid | input | 1 | Request present this cycle |
| reqType | input | 2 | Request type code |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWrData | input | DATA_W | Write data |
| errIn | input | 1 | Error event detected by the bridge |
| rspValid | output | 1 | Response for the previous cycle's request |
| rspClaim | output | 1 | Request claimed by the bridge |
| rspForward | output | 1 | Request passed to the secondary bus |
| rspAbort | output | 1 | Request unclaimed; initiator sees master abort |
| rspRdData | output | DATA_W | Read data returned by the bridge |
| errOut | output | 1 | Registered error report |
| secClkEn | output | NUM_CLK | Secondary clock enables |
| softRst | output | 1 | Internal reset pulse |

## Verification
The waking write is the case where two functions meet on one edge. A single Type 0 write from state 11 to 00 loads the power state and the vendor field, while the internal reset it triggers clears the standard field. The bench provokes this with a waking word whose standard field is nonzero. It judges the result by a later status read: the standard field must be zero, the vendor field must hold the written value and the state must be 00. It also checks that softRst and the returning clock enables appear in the same cycle, and that the pulse is gone one cycle later.

// File: rtl/pgate_pkg.sv
package pgate_pkg;

  typedef enum logic [1:0] {
    PS_D0    = 2'b00,
    PS_D1    = 2'b01,
    PS_D2    = 2'b10,
    PS_D3HOT = 2'b11
  } pwrState_e;

  typedef enum logic [1:0] {
    RQ_MEM  = 2'b00,
    RQ_IO   = 2'b01,
    RQ_CFG0 = 2'b10,
    RQ_CFG1 = 2'b11
  } reqKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // capture a response
    logic claim;
    logic fwd;
    logic abort;
    logic rdOnes;    // swallowed Type 1 read
    logic rdStatus;  // Type 0 read
    logic wrCfg;     // Type 0 write
    logic clrStd;    // wake reset: clear standard field
    logic clrAll;    // cold-off: hold everything at defaults
  } gateStrb_t;

endpackage

// File: rtl/pgate_ctrl.sv
module pgate_ctrl
  import pgate_pkg::*;
#(
  parameter int NUM_CLK = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               coldOff,
  input  logic               reqValid,
  input  logic [1:0]         reqType,
  input  logic               reqWrite,
  input  logic [1:0]         wrState,
  output gateStrb_t          strb,
  output pwrState_e          pwrState,
  output logic [NUM_CLK-1:0] secClkEn,
  output logic               softRst
);

  pwrState_e stateQ;
  reqKind_e  kind;
  logic      isLow;
  logic      wake;
  logic      clkOn;

  assign kind  = reqKind_e'(reqType);
  assign isLow = (stateQ != PS_D0);

  always_comb begin
    strb        = '0;
    strb.load   = reqValid;
    strb.clrAll = coldOff;
    if (reqValid) begin
      if (coldOff) begin
        strb.abort = 1'b1;
      end else begin
        unique case (kind)
          RQ_MEM, RQ_IO: begin
            if (isLow) strb.abort = 1'b1;
            else begin
              strb.claim = 1'b1;
              strb.fwd   = 1'b1;
            end
          end
          RQ_CFG0: begin
            strb.claim = 1'b1;
            if (reqWrite) strb.wrCfg = 1'b1;
            else          strb.rdStatus = 1'b1;
          end
          RQ_CFG1: begin
            strb.claim = 1'b1;
            if (!isLow)         strb.fwd    = 1'b1;
            else if (!reqWrite) strb.rdOnes = 1'b1;
          end
          default: ;
        endcase
      end
    end
    strb.clrStd = wake;
  end

  assign wake = reqValid && !coldOff && (kind == RQ_CFG0) && reqWrite &&
                (stateQ == PS_D3HOT) && (wrState == PS_D0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           stateQ <= PS_D0;
    else if (coldOff)    stateQ <= PS_D0;
    else if (strb.wrCfg) stateQ <= pwrState_e'(wrState);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) softRst <= 1'b0;
    else       softRst <= wake;
  end

  assign clkOn    = !coldOff && ((stateQ == PS_D0) || (stateQ == PS_D1));
  assign pwrState = stateQ;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CLK; gi++) begin : g_clkEn
      assign secClkEn[gi] = clkOn;
    end
  endgenerate

  // R7: the wake pulse lasts a single cycle
  a_r7_pulse_single: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> !softRst);

  // R7: a waking write lands in D0 with the pulse raised
  a_r7_wake_pulse: assert property (@(posedge clk) disable iff (!rstN)
    wake |=> (softRst && pwrState == PS_D0));

  // R6: writing a deep-sleep level turns the clocks off next cycle
  a_r6_clk_off: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrCfg && wrState[1] && !coldOff) |=> (secClkEn == '0));

  // R9: cold-off leaves the state at fully on
  a_r9_cold_state: assert property (@(posedge clk) disable iff (!rstN)
    coldOff |=> (pwrState == PS_D0));

endmodule

// File: rtl/pgate_dp.sv
module pgate_dp
  import pgate_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int STD_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  gateStrb_t         strb,
  input  pwrState_e         pwrState,
  input  logic [DATA_W-3:0] cfgData,
  input  logic              errIn,
  output logic              rspValid,
  output logic              rspClaim,
  output logic              rspForward,
  output logic              rspAbort,
  output logic [DATA_W-1:0] rspRdData,
  output logic              errOut
);

  localparam int VEND_W = DATA_W - STD_W - 2;

  logic [STD_W-1:0]  stdQ;
  logic [VEND_W-1:0] vendQ;
  logic [DATA_W-1:0] statusWord;
  logic [DATA_W-1:0] rdNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stdQ  <= '0;
      vendQ <= '0;
    end else if (strb.clrAll) begin
      stdQ  <= '0;
      vendQ <= '0;
    end else begin
      if (strb.wrCfg) vendQ <= cfgData[VEND_W-1:0];
      if (strb.clrStd)     stdQ <= '0;
      else if (strb.wrCfg) stdQ <= cfgData[DATA_W-3 -: STD_W];
    end
  end

  assign statusWord = {stdQ, vendQ, pwrState};

  always_comb begin
    if (strb.rdOnes)        rdNext = '1;
    else if (strb.rdStatus) rdNext = statusWord;
    else                    rdNext = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid   <= 1'b0;
      rspClaim   <= 1'b0;
      rspForward <= 1'b0;
      rspAbort   <= 1'b0;
      rspRdData  <= '0;
      errOut     <= 1'b0;
    end else begin
      rspValid   <= strb.load;
      rspClaim   <= strb.claim;
      rspForward <= strb.fwd;
      rspAbort   <= strb.abort;
      rspRdData  <= rdNext;
      errOut     <= errIn && !strb.clrAll;
    end
  end

  // R3: a response is either claimed or aborted, never both
  a_r3_claim_xor_abort: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $onehot({rspClaim, rspAbort}));

  // R2: forwarding only happens on a claimed request
  a_r2_fwd_claimed: assert property (@(posedge clk) disable iff (!rstN)
    rspForward |-> rspClaim);

  // R1: outputs stay quiet with no request
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> (!rspClaim && !rspAbort && !rspForward && rspRdData == '0));

endmodule

// File: rtl/pgate_top.sv
module pgate_top
  import pgate_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int STD_W   = 16,
  parameter int NUM_CLK = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               coldOff,
  input  logic               reqValid,
  input  logic [1:0]         reqType,
  input  logic               reqWrite,
  input  logic [DATA_W-1:0]  reqWrData,
  input  logic               errIn,
  output logic               rspValid,
  output logic               rspClaim,
  output logic               rspForward,
  output logic               rspAbort,
  output logic [DATA_W-1:0]  rspRdData,
  output logic               errOut,
  output logic [NUM_CLK-1:0] secClkEn,
  output logic               softRst
);

  gateStrb_t strb;
  pwrState_e pwrState;

  pgate_ctrl #(.NUM_CLK(NUM_CLK)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .coldOff  (coldOff),
    .reqValid (reqValid),
    .reqType  (reqType),
    .reqWrite (reqWrite),
    .wrState  (reqWrData[1:0]),
    .strb     (strb),
    .pwrState (pwrState),
    .secClkEn (secClkEn),
    .softRst  (softRst)
  );

  pgate_dp #(.DATA_W(DATA_W), .STD_W(STD_W)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .pwrState   (pwrState),
    .cfgData    (reqWrData[DATA_W-1:2]),
    .errIn      (errIn),
    .rspValid   (rspValid),
    .rspClaim   (rspClaim),
    .rspForward (rspForward),
    .rspAbort   (rspAbort),
    .rspRdData  (rspRdData),
    .errOut     (errOut)
  );

  // R9: cold-off requests are never claimed
  a_r9_cold_abort: assert property (@(posedge clk) disable iff (!rstN)
    (coldOff && reqValid) |=> (rspAbort && !rspClaim && !rspForward));

  // R1: one response per request, one cycle later
  a_r1_rsp_timing: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

endmodule

// File: tb/tb_pgate_top.sv
module tb_pgate_top;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        coldOff = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqType = 2'b00;
  logic        reqWrite = 1'b0;
  logic [31:0] reqWrData = '0;
  logic        errIn = 1'b0;
  logic        rspValid, rspClaim, rspForward, rspAbort, errOut, softRst;
  logic [31:0] rspRdData;
  logic [3:0]  secClkEn;

  int testCnt = 0;
  int failCnt = 0;

  always #(CLK_P/2) clk = ~clk;

  pgate_top dut (
    .clk(clk), .rstN(rstN), .coldOff(coldOff), .reqValid(reqValid),
    .reqType(reqType), .reqWrite(reqWrite), .reqWrData(reqWrData),
    .errIn(errIn), .rspValid(rspValid), .rspClaim(rspClaim),
    .rspForward(rspForward), .rspAbort(rspAbort), .rspRdData(rspRdData),
    .errOut(errOut), .secClkEn(secClkEn), .softRst(softRst)
  );

  // vector: [9:8] state, [7:6] type, [5] write, [4] claim, [3] forward,
  // [2] abort, [1:0] read kind (0 zero, 1 all ones, 2 status word)
  localparam logic [9:0] VEC [16] = '{
    10'b00_00_0_1_1_0_00, 10'b00_01_1_1_1_0_00, 10'b00_10_0_1_0_0_10,
    10'b00_11_0_1_1_0_00, 10'b00_11_1_1_1_0_00, 10'b01_00_1_0_0_1_00,
    10'b01_01_0_0_0_1_00, 10'b01_10_0_1_0_0_10, 10'b01_11_0_1_0_0_01,
    10'b10_00_0_0_0_1_00, 10'b10_11_1_1_0_0_00, 10'b10_10_0_1_0_0_10,
    10'b11_01_1_0_0_1_00, 10'b11_11_0_1_0_0_01, 10'b11_10_0_1_0_0_10,
    10'b11_10_1_1_0_0_00
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // drive at a negedge, response registered at the next posedge,
  // sampled at the negedge after it
  task automatic doReq(input logic [1:0] t, input logic w, input logic [31:0] d);
    @(negedge clk);
    reqValid  = 1'b1;
    reqType   = t;
    reqWrite  = w;
    reqWrData = d;
    @(negedge clk);
    reqValid  = 1'b0;
    reqWrite  = 1'b0;
  endtask

  task automatic setState(input logic [1:0] s);
    doReq(2'b10, 1'b1, {30'b0, s});
  endtask

  task automatic readStatus(input string req, input logic [31:0] exp);
    doReq(2'b10, 1'b0, '0);
    check(req, "status word", rspRdData, exp);
  endtask

  initial begin
    #(CLK_P * 150000);
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    logic [9:0]  vec;
    logic [31:0] expRd;
    string       tag;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1", "rspValid after reset", {31'b0, rspValid}, 32'd0);
    check("R1", "softRst after reset", {31'b0, softRst}, 32'd0);
    check("R6", "clock enables after reset", {28'b0, secClkEn}, 32'hF);
    readStatus("R1", 32'h0);
    check("R1", "rspValid one cycle after request", {31'b0, rspValid}, 32'd1);
    @(negedge clk);
    check("R1", "rspValid falls without request", {31'b0, rspValid}, 32'd0);

    // table walk: R2 R3 R4 R5 R6
    for (int i = 0; i < 16; i++) begin
      vec = VEC[i];
      setState(vec[9:8]);
      check("R6", "clock enables per state", {28'b0, secClkEn},
            (vec[9:8] < 2) ? 32'hF : 32'h0);
      doReq(vec[7:6], vec[5], {30'b0, vec[9:8]});
      if (vec[7:6] == 2'b10)      tag = "R4";
      else if (vec[9:8] == 2'b00) tag = "R2";
      else if (vec[7:6] == 2'b11) tag = "R5";
      else                        tag = "R3";
      case (vec[1:0])
        2'd1:    expRd = 32'hFFFF_FFFF;
        2'd2:    expRd = {30'b0, vec[9:8]};
        default: expRd = 32'h0;
      endcase
      check(tag, "claim", {31'b0, rspClaim}, {31'b0, vec[4]});
      check(tag, "forward", {31'b0, rspForward}, {31'b0, vec[3]});
      check(tag, "abort", {31'b0, rspAbort}, {31'b0, vec[2]});
      check(tag, "read data", rspRdData, expRd);
    end

    // R5: Type 1 write in D1 leaves all fields unchanged
    doReq(2'b10, 1'b1, {16'h7777, 14'h0055, 2'b01});
    doReq(2'b11, 1'b1, {16'h0000, 14'h0000, 2'b10});
    check("R5", "swallowed write not forwarded", {31'b0, rspForward}, 32'd0);
    readStatus("R5", {16'h7777, 14'h0055, 2'b01});

    // R7: wake from D3hot with reset and field load on one edge
    doReq(2'b10, 1'b1, {16'hABCD, 14'h1234, 2'b11});
    check("R6", "clocks off in D3hot", {28'b0, secClkEn}, 32'h0);
    readStatus("R4", {16'hABCD, 14'h1234, 2'b11});
    doReq(2'b10, 1'b1, {16'h5555, 14'h0AAA, 2'b00});
    check("R7", "softRst after waking write", {31'b0, softRst}, 32'd1);
    check("R6", "clocks back with the pulse", {28'b0, secClkEn}, 32'hF);
    @(negedge clk);
    check("R7", "softRst single cycle", {31'b0, softRst}, 32'd0);
    readStatus("R7", {16'h0000, 14'h0AAA, 2'b00});

    // R8: other transitions raise no reset
    doReq(2'b10, 1'b1, {16'hAAAA, 14'h0001, 2'b11});
    doReq(2'b10, 1'b1, {16'h1111, 14'h0002, 2'b01});
    check("R8", "no softRst D3hot to D1", {31'b0, softRst}, 32'd0);
    readStatus("R8", {16'h1111, 14'h0002, 2'b01});
    doReq(2'b10, 1'b1, {16'h2222, 14'h0003, 2'b10});
    doReq(2'b10, 1'b1, {16'h3333, 14'h0004, 2'b00});
    check("R8", "no softRst D2 to D0", {31'b0, softRst}, 32'd0);
    readStatus("R8", {16'h3333, 14'h0004, 2'b00});

    // R10: error reporting in a sleep state
    setState(2'b11);
    @(negedge clk);
    errIn = 1'b1;
    @(negedge clk);
    check("R10", "errOut in D3hot", {31'b0, errOut}, 32'd1);
    errIn = 1'b0;
    @(negedge clk);
    check("R10", "errOut clears", {31'b0, errOut}, 32'd0);

    // R9: cold-off
    doReq(2'b10, 1'b1, {16'h4444, 14'h0099, 2'b01});
    coldOff = 1'b1;
    errIn   = 1'b1;
    @(negedge clk);
    check("R9", "clocks off in cold", {28'b0, secClkEn}, 32'h0);
    check("R10", "errOut low in cold", {31'b0, errOut}, 32'd0);
    doReq(2'b00, 1'b0, '0);
    check("R9", "memory claim in cold", {31'b0, rspClaim}, 32'd0);
    check("R9", "memory abort in cold", {31'b0, rspAbort}, 32'd1);
    doReq(2'b10, 1'b0, '0);
    check("R9", "Type 0 claim in cold", {31'b0, rspClaim}, 32'd0);
    check("R9", "Type 0 read data in cold", rspRdData, 32'h0);
    doReq(2'b10, 1'b1, {16'h9999, 14'h0011, 2'b10});
    errIn   = 1'b0;
    coldOff = 1'b0;
    @(negedge clk);
    check("R9", "clocks back after cold", {28'b0, secClkEn}, 32'hF);
    readStatus("R9", 32'h0);

    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule